// File: doc/BRIEF.md
# Indirect Register Access Window

This block puts one 64-bit command word in front of a small bank of 8-bit controller registers. Software never addresses those registers directly. It writes a command word that names an operation code, a register index, a direction and a data byte, and sets the top bit of the word to start the access. The block carries out the access and then clears that top bit. Software polls the word until the bit drops. For a read, it then takes the result from the low byte of the word.

Only operation code 6 reaches the register bank. The bank holds these registers: own bus address, data byte, control, clock divider setting and extended own address. Index 3 is special. A write to it sets the clock divider, but a read of it returns the live status byte from the serial engine. A write to index 7 produces a one-cycle reset pulse for the engine. The register values leave the block on dedicated outputs, where the serial engine picks them up.

Top module: `indirect_reg_window`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `host_rdata` is zero, all register outputs are zero and `eng_rst_o` is low.
- R2: The word is decoded at these bit positions: valid is bit 63, read is bit 56 (1 = read, 0 = write), opcode is bits 60:57, register index is bits 34:32 and write data is bits 7:0. Bits 62:32 are stored as written and read back unchanged. On a write, bits 31:0 also read back unchanged.
- R3: A host write that is accepted while bit 63 of the write data is clear only stores the word. No register access starts and the register outputs keep their values.
- R4: For opcode 6, bit 63 of `host_rdata` reads 1 in the two cycles after the accepting clock edge. It reads 0 from the third edge on, and the access results are visible at that same point.
- R5: Writes with opcode 6 to indices 0, 1, 2, 3 and 4 load bits 7:0 into `own_addr_o`, `data_o`, `ctrl_o`, `clkdiv_o` and `own_addr_ext_o` respectively.
- R6: When a read with opcode 6 completes, bits 7:0 of the word hold the selected register and bits 31:8 are zero. A read of index 3 returns `status_in`, not the clock divider setting.
- R7: A write with opcode 6 to index 7 raises `eng_rst_o` for exactly one cycle, during the second cycle after acceptance, and changes no register output. Reads of indices 5, 6 and 7 return zero.
- R8: While bit 63 of the word is set, host writes are ignored. This includes a write on the clock edge at which the access completes.
- R9: Any opcode other than 6 completes one cycle after acceptance. It clears bits 31:0 of the word and touches no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word, valid bit and result included |
| status_in | input | 8 | Status byte from the serial engine, returned on reads of index 3 |
| own_addr_o | output | 8 | Own bus address register |
| own_addr_ext_o | output | 8 | Extended own address register |
| data_o | output | 8 | Data byte register |
| ctrl_o | output | 8 | Control register |
| clkdiv_o | output | 8 | Clock divider setting |
| eng_rst_o | output | 1 | One-cycle reset pulse to the serial engine |

## Verification
A new host write and the completion of an access can fall on the same clock edge. The completion clears the valid bit and loads the result into the low bits of the word, while the write would replace the whole word. To provoke this, the bench holds the write strobe high, carrying a conflicting command, from the edge after acceptance through the completion edge. It then checks two things: the word holds the result of the first command, and the control register holds the first command's byte, not the second's.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int WORD_W   = 64;
  localparam int IDX_W    = 3;
  localparam int OP_W     = 4;
  localparam int VALID_B  = 63;
  localparam int RNW_B    = 56;
  localparam int OP_LO    = 57;
  localparam int IDX_LO   = 32;
  localparam int DATA_W   = 32;
  localparam logic [OP_W-1:0] OP_BANK = 4'd6;

  localparam logic [IDX_W-1:0] IDX_OWN  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_DATA = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CLK  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_EXT  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_RST  = 3'd7;
  localparam int               LAST_RW  = 4;
endpackage

// File: rtl/irw_seq.sv
module irw_seq #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic op_ok,
  output logic busy,
  output logic acc_stb,
  output logic done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy    = busy_q;
  assign acc_stb = busy_q && op_ok && (cnt_q == '0);
  assign done    = busy_q && (op_ok ? (cnt_q == LAST) : (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_ok && cnt_q == '0) |=> busy_q);
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST));
  // R9
  bad_op_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !op_ok) |=> !busy_q);
endmodule

// File: rtl/irw_bank.sv
module irw_bank
  import irw_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_stb,
  input  logic             rnw,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wbyte,
  input  logic [REG_W-1:0] status_in,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] own_addr,
  output logic [REG_W-1:0] own_ext,
  output logic [REG_W-1:0] data_reg,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] clkdiv,
  output logic             eng_rst
);
  localparam int NREG = 1 << IDX_W;

  logic [REG_W-1:0] regs_q [NREG];
  logic [REG_W-1:0] rd_q;
  logic             eng_rst_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i <= LAST_RW) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[i] <= '0;
        else if (acc_stb && !rnw && idx == IDX_W'(i))
          regs_q[i] <= wbyte;
      end
    end else begin : g_none
      assign regs_q[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      eng_rst_q <= 1'b0;
    end else begin
      eng_rst_q <= acc_stb && !rnw && (idx == IDX_RST);
      if (acc_stb && rnw)
        rd_q <= (idx == IDX_CLK) ? status_in : regs_q[idx];
    end
  end

  assign rd_data  = rd_q;
  assign eng_rst  = eng_rst_q;
  assign own_addr = regs_q[IDX_OWN];
  assign data_reg = regs_q[IDX_DATA];
  assign ctrl     = regs_q[IDX_CTRL];
  assign clkdiv   = regs_q[IDX_CLK];
  assign own_ext  = regs_q[IDX_EXT];

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst_q |=> !eng_rst_q);
endmodule

// File: rtl/indirect_reg_window.sv
module indirect_reg_window
  import irw_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int LAT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [REG_W-1:0]  status_in,
  output logic [REG_W-1:0]  own_addr_o,
  output logic [REG_W-1:0]  own_addr_ext_o,
  output logic [REG_W-1:0]  data_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  clkdiv_o,
  output logic              eng_rst_o
);
  logic [WORD_W-1:0] word_q;
  logic              busy, acc_stb, done, start, accept;
  logic              op_ok, rnw;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  rd_data;

  assign op_ok  = word_q[OP_LO +: OP_W] == OP_BANK;
  assign rnw    = word_q[RNW_B];
  assign idx    = word_q[IDX_LO +: IDX_W];
  assign accept = host_wr && !busy;
  assign start  = accept && host_wdata[VALID_B];

  irw_seq #(.LAT(LAT)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_ok   (op_ok),
    .busy    (busy),
    .acc_stb (acc_stb),
    .done    (done)
  );

  irw_bank #(.REG_W(REG_W)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .acc_stb   (acc_stb),
    .rnw       (rnw),
    .idx       (idx),
    .wbyte     (word_q[REG_W-1:0]),
    .status_in (status_in),
    .rd_data   (rd_data),
    .own_addr  (own_addr_o),
    .own_ext   (own_addr_ext_o),
    .data_reg  (data_o),
    .ctrl      (ctrl_o),
    .clkdiv    (clkdiv_o),
    .eng_rst   (eng_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= host_wdata;
    end else if (done) begin
      word_q[VALID_B] <= 1'b0;
      if (!op_ok)
        word_q[DATA_W-1:0] <= '0;
      else if (rnw)
        word_q[DATA_W-1:0] <= DATA_W'(rd_data);
    end
  end

  assign host_rdata = word_q;

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !done) |=> (word_q[62:0] == $past(word_q[62:0])));
  // R8
  done_edge_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && done) |=> (word_q[62:32] == $past(word_q[62:32])));
  // R9
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !op_ok) |=> (word_q[DATA_W-1:0] == '0));
  // R5
  regs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(ctrl_o) && $stable(clkdiv_o) && $stable(own_addr_o));
endmodule

// File: tb/test_indirect_reg_window.sv
module test_indirect_reg_window;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  localparam logic [63:0] VEC_CMD [NV] = '{
    64'hCC12_3408_0000_0077, 64'h8C00_0002_0000_0040,
    64'h8C00_0003_0000_002B, 64'h8C00_0004_0000_0011,
    64'h8C00_0001_DEAD_BEA5, 64'h8D00_0000_FFFF_FFFF,
    64'h8D00_0002_0000_0000, 64'h8D00_0004_0000_0000,
    64'h8D00_0001_0000_0000, 64'h8D00_0003_0000_0000,
    64'h8D00_0005_0000_0033, 64'h8C00_0007_0000_0001};
  localparam logic [63:0] VEC_EXP [NV] = '{
    64'h4C12_3408_0000_0077, 64'h0C00_0002_0000_0040,
    64'h0C00_0003_0000_002B, 64'h0C00_0004_0000_0011,
    64'h0C00_0001_DEAD_BEA5, 64'h0D00_0000_0000_0077,
    64'h0D00_0002_0000_0040, 64'h0D00_0004_0000_0011,
    64'h0D00_0001_0000_00A5, 64'h0D00_0003_0000_00F8,
    64'h0D00_0005_0000_0000, 64'h0C00_0007_0000_0001};

  logic        clk = 0;
  logic        rst = 1;
  logic        host_wr = 0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic [7:0]  status_in = 8'hF8;
  logic [7:0]  own_addr_o, own_addr_ext_o, data_o, ctrl_o, clkdiv_o;
  logic        eng_rst_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_reg_window i_indirect_reg_window (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .status_in(status_in),
    .own_addr_o(own_addr_o), .own_addr_ext_o(own_addr_ext_o),
    .data_o(data_o), .ctrl_o(ctrl_o), .clkdiv_o(clkdiv_o),
    .eng_rst_o(eng_rst_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [63:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", host_rdata, 64'h0);
    chk("R1", {ctrl_o, clkdiv_o, own_addr_o, data_o, own_addr_ext_o, 7'd0, eng_rst_o}, 48'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", host_rdata, 64'h0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC_CMD[v]);
      chk("R4", 64'(host_rdata[63]), 64'h1);
      @(negedge clk);
      chk("R4", 64'(host_rdata[63]), 64'h1);
      chk("R7", 64'(eng_rst_o), (v == NV-1) ? 64'h1 : 64'h0);
      @(negedge clk);
      chk(v == 0 ? "R2" : (v >= 5 ? "R6" : "R5"), host_rdata, VEC_EXP[v]);
      chk("R7", 64'(eng_rst_o), 64'h0);
    end
    // R5 register outputs, unchanged by index 7 write (R7)
    chk("R5", 64'(own_addr_o), 64'h77);
    chk("R5", 64'(data_o), 64'hA5);
    chk("R5", 64'(ctrl_o), 64'h40);
    chk("R5", 64'(clkdiv_o), 64'h2B);
    chk("R7", 64'(own_addr_ext_o), 64'h11);

    // R3 store without starting an access
    issue(64'h0C00_0002_0000_00FF);
    repeat (3) @(negedge clk);
    chk("R3", host_rdata, 64'h0C00_0002_0000_00FF);
    chk("R3", 64'(ctrl_o), 64'h40);

    // R8 writes during busy, held through the completion edge
    issue(64'h8C00_0002_0000_0055);
    host_wr = 1'b1;
    host_wdata = 64'h8D00_0004_0000_0066;
    @(negedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    chk("R8", host_rdata, 64'h0C00_0002_0000_0055);
    chk("R8", 64'(ctrl_o), 64'h55);
    @(negedge clk);
    chk("R8", host_rdata, 64'h0C00_0002_0000_0055);

    // R9 unsupported opcode
    issue(64'h8500_0002_0000_1234);
    chk("R9", 64'(host_rdata[63]), 64'h1);
    @(negedge clk);
    chk("R9", host_rdata, 64'h0500_0002_0000_0000);
    chk("R9", 64'(ctrl_o), 64'h55);

    // R6 status follows the live input
    status_in = 8'h3C;
    issue(64'h8D00_0003_0000_0000);
    repeat (2) @(negedge clk);
    chk("R6", host_rdata, 64'h0D00_0003_0000_003C);

    // R1 reset again clears the registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 64'(ctrl_o), 64'h0);
    chk("R1", host_rdata, 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule